// File: doc/BRIEF.md
# Multi-Path Slotted Interval Timer

This block keeps an hour-long running clock for each of several timing paths. All paths advance on one shared tick enable. The nominal tick is 100 kHz, taken from a 5 MHz system clock. Each path counts ticks into whole seconds and emits a one-clock strobe when each second completes. It also keeps seconds and minutes in BCD for a display. Every five minutes it starts a slot pulse.

The slot pulses visit twelve slot lines in turn, one for each five-minute mark of the hour. A slot line is active-low and stays low for a fixed number of ticks, nominally 100 ticks, or 1 ms. Each path has its own twelve-bit vector of slot enables. While a slot line is low and its enable bit is set, the path drives an active-low start request. Downstream equipment uses that request to begin a timed sequence.

The tick rate, slot length and pulse length are parameters. The block can therefore be shrunk to run an hour in a few thousand cycles.

Top module: `slot_timer_bank`

## Requirements
- R1: A synchronous active-high `rst` sets every path to 00:00 and drives `pps` low. It also drives every `slot_n` and `start_req_n` bit high, starting in the cycle after the reset edge.
- R2: A second completes after exactly TICKS_PER_SEC clock edges with `tick_en` high. Clock edges with `tick_en` low change neither the sub-second count nor the time.
- R3: `pps[p]` is high for exactly one clock cycle. That cycle follows the tick that completes a second, and it is the same cycle in which the seconds value changes.
- R4: Seconds are BCD on `sec_bcd[p*8+:8]`, with tens in bits 7:4 and ones in bits 3:0. They run from 00 to 59, and the step from 59 back to 00 advances the minutes.
- R5: Minutes are BCD on `min_bcd[p*8+:8]`, using the same field layout as seconds. They run from 00 to 59 and wrap to 00 after 59:59.
- R6: When the time becomes mm:00 and mm is a multiple of SLOT_MINUTES, slot line k = mm/SLOT_MINUTES goes low. That line is `slot_n[p*NUM_SLOTS+k]`, and it goes low in the cycle the new time appears. At most one slot line per path is low at any time.
- R7: Within an hour the slots fire in the order 1, 2, ..., 11 and then 0. Slot 0 fires at the hour wrap and not at reset.
- R8: `start_req_n[p]` is low exactly while slot line k of path p is low and `slot_en[p*NUM_SLOTS+k]` is 1. The enable is read live during the pulse.
- R9: Each path's request depends only on that path's own enable field. All paths count the same shared tick.
- R10: The slot pulse lasts PULSE_TICKS ticks, not clock cycles. Clock cycles without `tick_en` stretch the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Shared timing tick, one clock wide |
| slot_en | input | NUM_PATHS*NUM_SLOTS | Per-path slot enable vectors, path p at bits p*NUM_SLOTS upward |
| pps | output | NUM_PATHS | One-cycle strobe at each completed second |
| sec_bcd | output | NUM_PATHS*8 | BCD seconds per path |
| min_bcd | output | NUM_PATHS*8 | BCD minutes per path |
| slot_n | output | NUM_PATHS*NUM_SLOTS | Active-low slot lines per path |
| start_req_n | output | NUM_PATHS | Active-low start request per path |

## Verification
The hardest states to reach from the ports are the hour wrap, which fires slot 0, and a slot pulse that straddles gaps in the tick. At nominal rates the hour wrap needs 360 million ticks. The bench shrinks the design by overriding the parameters to four ticks per second and a three-tick pulse, so a full hour and more fits in about 21,000 cycles. A pseudo-random pattern withholds about one tick in eight. This stretches pulses and second boundaries across idle cycles. The enable vectors are swapped partway through the run, and reset is asserted again while the time is non-zero.

// File: rtl/slot_timer_pkg.sv
package slot_timer_pkg;

    localparam int unsigned MINUTES_PER_HOUR = 60;

    typedef struct packed {
        logic [3:0] tens;
        logic [3:0] ones;
    } bcd2_t;

    typedef struct packed {
        bcd2_t mins;
        bcd2_t secs;
    } clock_time_t;

    // Advance a two-digit BCD value that wraps from 59 to 00.
    function automatic bcd2_t bcd_next(input bcd2_t v);
        bcd2_t r;
        if (v.ones == 4'd9) begin
            r.ones = 4'd0;
            r.tens = (v.tens == 4'd5) ? 4'd0 : v.tens + 4'd1;
        end else begin
            r.ones = v.ones + 4'd1;
            r.tens = v.tens;
        end
        return r;
    endfunction

    function automatic logic [6:0] bcd_value(input bcd2_t v);
        return 7'(v.tens) * 7'd10 + 7'(v.ones);
    endfunction

    function automatic logic bcd_is_59(input bcd2_t v);
        return (v.tens == 4'd5) && (v.ones == 4'd9);
    endfunction

    function automatic logic bcd_legal(input bcd2_t v);
        return (v.tens <= 4'd5) && (v.ones <= 4'd9);
    endfunction

endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
    parameter int unsigned TICKS_PER_SEC = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    output logic sec_step,
    output logic pps_o
);
    localparam int unsigned SW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [SW-1:0] LAST = SW'(TICKS_PER_SEC - 1);

    logic [SW-1:0] sub_q;
    logic          at_last;

    assign at_last  = (sub_q == LAST);
    assign sec_step = tick_en && at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            sub_q <= '0;
            pps_o <= 1'b0;
        end else begin
            pps_o <= sec_step;
            if (tick_en) begin
                sub_q <= at_last ? '0 : sub_q + 1'b1;
            end
        end
    end

    a_r3_pps_single: assert property (@(posedge clk) disable iff (rst)
        pps_o |=> !pps_o);

    a_r2_sub_range: assert property (@(posedge clk) disable iff (rst)
        sub_q <= LAST);

    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(sub_q));

endmodule

// File: rtl/bcd_clock.sv
module bcd_clock
    import slot_timer_pkg::*;
#(
    parameter int unsigned SLOT_MINUTES = 5,
    parameter int unsigned IW           = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_step,
    output clock_time_t       time_o,
    output logic              slot_start,
    output logic [IW-1:0]     slot_next_idx
);
    clock_time_t time_q;
    logic [6:0]  min_after;
    logic        sec_wrap;

    assign sec_wrap = bcd_is_59(time_q.secs);

    always_comb begin
        if (bcd_is_59(time_q.mins)) begin
            min_after = 7'd0;
        end else begin
            min_after = bcd_value(time_q.mins) + 7'd1;
        end
    end

    assign slot_start    = sec_step && sec_wrap && ((32'(min_after) % SLOT_MINUTES) == 0);
    assign slot_next_idx = IW'(32'(min_after) / SLOT_MINUTES);

    always_ff @(posedge clk) begin
        if (rst) begin
            time_q <= '0;
        end else if (sec_step) begin
            time_q.secs <= bcd_next(time_q.secs);
            if (sec_wrap) begin
                time_q.mins <= bcd_next(time_q.mins);
            end
        end
    end

    assign time_o = time_q;

    a_r4_sec_legal: assert property (@(posedge clk) disable iff (rst)
        bcd_legal(time_q.secs));

    a_r5_min_legal: assert property (@(posedge clk) disable iff (rst)
        bcd_legal(time_q.mins));

    a_r4_minute_only_on_wrap: assert property (@(posedge clk) disable iff (rst)
        !(sec_step && sec_wrap) |=> $stable(time_q.mins));

endmodule

// File: rtl/slot_sequencer.sv
module slot_sequencer #(
    parameter int unsigned NUM_SLOTS   = 12,
    parameter int unsigned PULSE_TICKS = 100,
    parameter int unsigned IW          = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_en,
    input  logic                 slot_start,
    input  logic [IW-1:0]        slot_next_idx,
    input  logic [NUM_SLOTS-1:0] slot_en,
    output logic [NUM_SLOTS-1:0] slot_n_o,
    output logic                 start_req_n_o
);
    localparam int unsigned CW = $clog2(PULSE_TICKS + 1);

    typedef struct packed {
        logic [IW-1:0] idx;
        logic [CW-1:0] left;
    } pulse_state_t;

    pulse_state_t st_q;
    logic         active;
    logic [NUM_SLOTS-1:0] hit;

    assign active = (st_q.left != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else if (slot_start) begin
            st_q.idx  <= slot_next_idx;
            st_q.left <= CW'(PULSE_TICKS);
        end else if (tick_en && active) begin
            st_q.left <= st_q.left - 1'b1;
        end
    end

    for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_line
        assign slot_n_o[k] = !(active && (st_q.idx == IW'(k)));
        assign hit[k]      = !slot_n_o[k] && slot_en[k];
    end

    assign start_req_n_o = ~|hit;

    a_r6_one_line_low: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~slot_n_o));

    a_r8_request_needs_line: assert property (@(posedge clk) disable iff (rst)
        !start_req_n_o |-> !(&slot_n_o));

    a_r10_idle_keeps_pulse: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !slot_start) |=> $stable(st_q.left));

endmodule

// File: rtl/path_timer.sv
module path_timer
    import slot_timer_pkg::*;
#(
    parameter int unsigned TICKS_PER_SEC = 100000,
    parameter int unsigned SLOT_MINUTES  = 5,
    parameter int unsigned PULSE_TICKS   = 100,
    parameter int unsigned NUM_SLOTS     = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick_en,
    input  logic [NUM_SLOTS-1:0] slot_en,
    output logic                 pps_o,
    output logic [7:0]           sec_o,
    output logic [7:0]           min_o,
    output logic [NUM_SLOTS-1:0] slot_n_o,
    output logic                 start_req_n_o
);
    localparam int unsigned IW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    logic          sec_step;
    logic          slot_start;
    logic [IW-1:0] slot_next_idx;
    clock_time_t   time_w;

    tick_prescaler #(
        .TICKS_PER_SEC (TICKS_PER_SEC)
    ) u_prescaler (
        .clk      (clk),
        .rst      (rst),
        .tick_en  (tick_en),
        .sec_step (sec_step),
        .pps_o    (pps_o)
    );

    bcd_clock #(
        .SLOT_MINUTES (SLOT_MINUTES),
        .IW           (IW)
    ) u_clock (
        .clk           (clk),
        .rst           (rst),
        .sec_step      (sec_step),
        .time_o        (time_w),
        .slot_start    (slot_start),
        .slot_next_idx (slot_next_idx)
    );

    slot_sequencer #(
        .NUM_SLOTS   (NUM_SLOTS),
        .PULSE_TICKS (PULSE_TICKS),
        .IW          (IW)
    ) u_sequencer (
        .clk           (clk),
        .rst           (rst),
        .tick_en       (tick_en),
        .slot_start    (slot_start),
        .slot_next_idx (slot_next_idx),
        .slot_en       (slot_en),
        .slot_n_o      (slot_n_o),
        .start_req_n_o (start_req_n_o)
    );

    assign sec_o = time_w.secs;
    assign min_o = time_w.mins;

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!pps_o && (&slot_n_o) && start_req_n_o && (time_w == '0)));

    a_r6_slot_on_boundary: assert property (@(posedge clk) disable iff (rst)
        $fell(&slot_n_o) |-> ((time_w.secs == '0) &&
                              ((32'(bcd_value(time_w.mins)) % SLOT_MINUTES) == 0)));

    a_r3_pps_with_second: assert property (@(posedge clk) disable iff (rst)
        pps_o |-> !$stable(time_w.secs));

endmodule

// File: rtl/slot_timer_bank.sv
module slot_timer_bank #(
    parameter int unsigned NUM_PATHS     = 3,
    parameter int unsigned TICKS_PER_SEC = 100000,
    parameter int unsigned SLOT_MINUTES  = 5,
    parameter int unsigned PULSE_TICKS   = 100,
    localparam int unsigned NUM_SLOTS    = slot_timer_pkg::MINUTES_PER_HOUR / SLOT_MINUTES
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           tick_en,
    input  logic [NUM_PATHS*NUM_SLOTS-1:0] slot_en,
    output logic [NUM_PATHS-1:0]           pps,
    output logic [NUM_PATHS*8-1:0]         sec_bcd,
    output logic [NUM_PATHS*8-1:0]         min_bcd,
    output logic [NUM_PATHS*NUM_SLOTS-1:0] slot_n,
    output logic [NUM_PATHS-1:0]           start_req_n
);

    for (genvar p = 0; p < NUM_PATHS; p++) begin : g_path
        path_timer #(
            .TICKS_PER_SEC (TICKS_PER_SEC),
            .SLOT_MINUTES  (SLOT_MINUTES),
            .PULSE_TICKS   (PULSE_TICKS),
            .NUM_SLOTS     (NUM_SLOTS)
        ) u_path (
            .clk           (clk),
            .rst           (rst),
            .tick_en       (tick_en),
            .slot_en       (slot_en[p*NUM_SLOTS +: NUM_SLOTS]),
            .pps_o         (pps[p]),
            .sec_o         (sec_bcd[p*8 +: 8]),
            .min_o         (min_bcd[p*8 +: 8]),
            .slot_n_o      (slot_n[p*NUM_SLOTS +: NUM_SLOTS]),
            .start_req_n_o (start_req_n[p])
        );
    end

    a_r9_paths_in_step: assert property (@(posedge clk) disable iff (rst)
        (sec_bcd[7:0] == sec_bcd[NUM_PATHS*8-1 -: 8]) &&
        (min_bcd[7:0] == min_bcd[NUM_PATHS*8-1 -: 8]));

endmodule

// File: tb/slot_timer_bank_bench.sv
module slot_timer_bank_bench;
    localparam int NP  = 3;
    localparam int TPS = 4;
    localparam int SM  = 5;
    localparam int PT  = 3;
    localparam int NS  = 60 / SM;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               tick_en = 1'b0;
    logic [NP*NS-1:0]   slot_en;
    logic [NP-1:0]      pps;
    logic [NP*8-1:0]    sec_bcd;
    logic [NP*8-1:0]    min_bcd;
    logic [NP*NS-1:0]   slot_n;
    logic [NP-1:0]      start_req_n;

    slot_timer_bank #(
        .NUM_PATHS     (NP),
        .TICKS_PER_SEC (TPS),
        .SLOT_MINUTES  (SM),
        .PULSE_TICKS   (PT)
    ) u_slot_timer_bank (
        .clk         (clk),
        .rst         (rst),
        .tick_en     (tick_en),
        .slot_en     (slot_en),
        .pps         (pps),
        .sec_bcd     (sec_bcd),
        .min_bcd     (min_bcd),
        .slot_n      (slot_n),
        .start_req_n (start_req_n)
    );

    always #4 clk = ~clk;

    int total = 0;
    int bad   = 0;

    // behavioural reference state
    int m_sub, m_sec, m_min, m_left, m_idx;
    bit m_pps;
    int pps_seen = 0;
    int ticks_driven = 0;
    int order_q[$];
    logic [NS-1:0] prev0 = '1;

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_step(input bit r, input bit t);
        bit start;
        start = 1'b0;
        if (r) begin
            m_sub = 0; m_sec = 0; m_min = 0; m_left = 0; m_idx = 0; m_pps = 0;
            return;
        end
        m_pps = 0;
        if (t) begin
            if (m_sub == TPS - 1) begin
                m_sub = 0;
                m_pps = 1;
                if (m_sec == 59) begin
                    m_sec = 0;
                    m_min = (m_min + 1) % 60;
                    if (m_min % SM == 0) begin
                        m_idx  = m_min / SM;
                        m_left = PT;
                        start  = 1'b1;
                    end
                end else begin
                    m_sec++;
                end
            end else begin
                m_sub++;
            end
            if (!start && m_left > 0) m_left--;
        end
    endtask

    task automatic compare_all();
        for (int p = 0; p < NP; p++) begin
            logic [NS-1:0] es;
            logic er;
            es = '1;
            if (m_left > 0) es[m_idx] = 1'b0;
            er = !((m_left > 0) && slot_en[p*NS + m_idx]);
            chk($sformatf("R3 pps path%0d", p), 64'(pps[p]), 64'(m_pps));
            chk($sformatf("R4 seconds path%0d", p), 64'(sec_bcd[p*8 +: 8]),
                64'({4'(m_sec / 10), 4'(m_sec % 10)}));
            chk($sformatf("R5 minutes path%0d", p), 64'(min_bcd[p*8 +: 8]),
                64'({4'(m_min / 10), 4'(m_min % 10)}));
            chk($sformatf("R6/R10 slot lines path%0d", p), 64'(slot_n[p*NS +: NS]), 64'(es));
            chk($sformatf("R8/R9 start request path%0d", p), 64'(start_req_n[p]), 64'(er));
        end
    endtask

    task automatic observe();
        if (pps[0]) pps_seen++;
        if ((&prev0) && !(&slot_n[0 +: NS])) begin
            for (int k = 0; k < NS; k++) if (!slot_n[k]) order_q.push_back(k);
        end
        prev0 = slot_n[0 +: NS];
    endtask

    task automatic check_reset_state();
        chk("R1 seconds zero", 64'(sec_bcd), 64'(0));
        chk("R1 minutes zero", 64'(min_bcd), 64'(0));
        chk("R1 pps low", 64'(pps), 64'(0));
        chk("R1 slot lines high", 64'(slot_n), 64'({NP*NS{1'b1}}));
        chk("R1 requests high", 64'(start_req_n), 64'({NP{1'b1}}));
    endtask

    initial begin
        #1_000_000;
        bad++;
        $display("FAIL watchdog expired: got=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        bit tv;
        lfsr = 32'h1234_ACE1;
        slot_en = {12'h0AA, 12'hFFF, 12'h821};
        rst = 1'b1;
        tick_en = 1'b1;
        model_step(1'b1, 1'b1);

        for (int i = 0; i < 21000; i++) begin
            @(negedge clk);
            if (i == 0) check_reset_state();
            compare_all();
            observe();
            if (i == 9000) slot_en = {12'hFFF, 12'h0F0, 12'h555};
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            tv = (lfsr[2:0] != 3'd0);
            rst = 1'b0;
            tick_en = tv;
            if (tv) ticks_driven++;
            model_step(1'b0, tv);
        end
        @(negedge clk);
        compare_all();
        observe();

        // R2: one second per TPS ticks, idle cycles ignored
        chk("R2 seconds per tick count", 64'(pps_seen), 64'(ticks_driven / TPS));

        // R7: slot order 1..11 then 0 through the hour wrap
        chk("R7 slot count", 64'(order_q.size() >= NS), 64'(1));
        for (int k = 0; k < order_q.size(); k++) begin
            chk($sformatf("R7 slot order entry %0d", k), 64'(order_q[k]), 64'((k + 1) % NS));
        end

        // R1: reset again while the clock is running
        rst = 1'b1;
        tick_en = 1'b1;
        model_step(1'b1, 1'b1);
        @(negedge clk);
        check_reset_state();
        compare_all();
        for (int i = 0; i < 40; i++) begin
            rst = 1'b0;
            tick_en = 1'b1;
            model_step(1'b0, 1'b1);
            @(negedge clk);
            compare_all();
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule